// File: doc/BRIEF.md
# Duplicate Node Address Detector

This block decides whether some other station on a token-passing network is already using the local node address. It observes every token that the line decoder reports. When a token is addressed to the local node ID, it opens a short response-wait window. If a response strobe arrives while that window is open, some other station must have answered on behalf of the same address. The block then sets a sticky duplicate flag, and the flag stays set until the host reads the diagnostic status.

The host loads a non-zero node ID and then leaves the transmitter disabled until the uniqueness check has had time to run. To support this, the block measures elapsed time with a prescaled millisecond tick and raises a probe-done indication once the detection bound has elapsed. The bound is the short one when both timeout-select bits are 1 and the long one for any other setting. The detector stays idle while the node ID is zero or while the core is held in reset.

Top module: `dupid_detect`

## Requirements
- R1: After the synchronous reset `rst`, `dup_flag_o` and `probe_done_o` are 0.
- R2: A response strobe arriving 1 to RESP_WIN cycles after a token whose destination ID equals `node_id_i` sets `dup_flag_o` at the next clock edge.
- R3: A response arriving RESP_WIN+1 or more cycles after the matching token, or with no matching token before it, leaves `dup_flag_o` unchanged.
- R4: A token whose destination ID differs from `node_id_i` opens no window, and it closes any window that is already open.
- R5: A response in the same cycle as the matching token does not count, because the window starts in the cycle after the token.
- R6: `dup_flag_o` holds at 1 until a cycle with `stat_rd_i` high, and it reads 0 after that clock edge.
- R7: If a status read and a new detection occur in the same cycle, `dup_flag_o` stays 1.
- R8: While `node_id_i` is 0 or `core_rst_i` is 1, no detection occurs. `core_rst_i` also clears `dup_flag_o` and restarts the time bound.
- R9: `probe_done_o` rises after L*CLK_PER_MS+1 consecutive active cycles, where L is SHORT_MS when `tmo_sel_i` is 2'b11 and LONG_MS for any other value. It stays high until the detector goes inactive.
- R10: Each window yields at most one detection, because a detecting response closes the window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| core_rst_i | input | 1 | Core held in reset; detector idle, flag and timer cleared |
| node_id_i | input | ID_W | Local node address; 0 disables the detector |
| tok_seen_i | input | 1 | One-cycle strobe: a token was observed |
| tok_did_i | input | ID_W | Destination ID of the observed token |
| resp_seen_i | input | 1 | One-cycle strobe: a response to a token was observed |
| tmo_sel_i | input | 2 | Timeout select; 2'b11 picks the short bound |
| stat_rd_i | input | 1 | Host read of the diagnostic status (clears the flag) |
| dup_flag_o | output | 1 | Sticky duplicate-address flag |
| probe_done_o | output | 1 | Detection time bound has elapsed |

## Verification
The bench tests both edges of the response window: a response at offset RESP_WIN must set the flag, while one at RESP_WIN+1 must not. A design that is off by one in either direction gives the wrong result at one of these points. It sends a response in the same cycle as the matching token, and a foreign token between a matching token and its response; a design that opens the window too early, or that ignores foreign tokens, would raise a false duplicate in these cases. A read that coincides with a detection and a second response after a detection catch a design that lets the read take priority, or that reports twice per window. The probe-done edge is checked at its exact cycle under both timeout settings, and a random token and response stream is compared cycle by cycle against a bench model.

// File: rtl/dupid_pkg.sv
package dupid_pkg;
  // classification of the token strobe in a cycle
  typedef enum logic [1:0] {
    TOK_NONE  = 2'd0,
    TOK_MATCH = 2'd1,
    TOK_OTHER = 2'd2
  } tok_cls_e;

  // timeout-select value that picks the short bound
  localparam logic [1:0] TMO_SHORT_SEL = 2'b11;
endpackage

// File: rtl/dupid_ms_tick.sv
module dupid_ms_tick #(
  parameter int CLK_PER_MS = 125000
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  output logic tick_o
);
  localparam int PW = (CLK_PER_MS > 1) ? $clog2(CLK_PER_MS) : 1;
  localparam logic [PW-1:0] LAST = PW'(CLK_PER_MS - 1);

  logic [PW-1:0] presc_q;

  assign tick_o = run_i && (presc_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      presc_q <= '0;
    end else if (presc_q == LAST) begin
      presc_q <= '0;
    end else begin
      presc_q <= presc_q + 1'b1;
    end
  end

  generate
    if (CLK_PER_MS > 1) begin : g_pulse_chk
      // R9
      tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/dupid_bound_timer.sv
module dupid_bound_timer #(
  parameter int SHORT_MS = 210,
  parameter int LONG_MS  = 420
) (
  input  logic clk,
  input  logic rst,
  input  logic run_i,
  input  logic tick_i,
  input  logic short_i,
  output logic done_o
);
  localparam int MAXMS = (LONG_MS > SHORT_MS) ? LONG_MS : SHORT_MS;
  localparam int MW = $clog2(MAXMS + 1);

  logic [MW-1:0] ms_q;
  logic [MW-1:0] limit;
  logic          done_q;

  assign limit = short_i ? MW'(SHORT_MS) : MW'(LONG_MS);

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      ms_q   <= '0;
      done_q <= 1'b0;
    end else begin
      if (tick_i && (ms_q < limit)) begin
        ms_q <= ms_q + 1'b1;
      end
      done_q <= (ms_q >= limit);
    end
  end

  assign done_o = done_q;

  // R9
  done_drop_chk: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !done_o);

  // R9
  ms_cap_chk: assert property (@(posedge clk) disable iff (rst)
    ms_q <= MW'(MAXMS));
endmodule

// File: rtl/dupid_resp_window.sv
module dupid_resp_window
  import dupid_pkg::*;
#(
  parameter int RESP_WIN = 64
) (
  input  logic     clk,
  input  logic     rst,
  input  logic     active_i,
  input  tok_cls_e tok_cls_i,
  input  logic     resp_i,
  output logic     hit_o,
  output logic     open_o
);
  localparam int WW = $clog2(RESP_WIN + 1);
  localparam logic [WW-1:0] WIN_LEN = WW'(RESP_WIN);

  logic [WW-1:0] cnt_q;

  assign open_o = (cnt_q != '0);
  assign hit_o  = active_i && open_o && resp_i;

  always_ff @(posedge clk) begin
    if (rst || !active_i) begin
      cnt_q <= '0;
    end else if (tok_cls_i == TOK_MATCH) begin
      cnt_q <= WIN_LEN;
    end else if (hit_o || (tok_cls_i == TOK_OTHER)) begin
      cnt_q <= '0;
    end else if (open_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R3
  win_len_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= WIN_LEN);

  // R10
  hit_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_o && (tok_cls_i != TOK_MATCH)) |=> !open_o);

  // R4
  other_tok_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (tok_cls_i == TOK_OTHER) |=> !open_o);

  // R5
  match_opens_chk: assert property (@(posedge clk) disable iff (rst)
    (active_i && tok_cls_i == TOK_MATCH) |=> open_o);
endmodule

// File: rtl/dupid_status_flag.sv
module dupid_status_flag (
  input  logic clk,
  input  logic rst,
  input  logic clr_all_i,
  input  logic set_i,
  input  logic rd_i,
  output logic flag_o
);
  logic flag_q;

  always_ff @(posedge clk) begin
    if (rst || clr_all_i) begin
      flag_q <= 1'b0;
    end else if (set_i) begin
      flag_q <= 1'b1;
    end else if (rd_i) begin
      flag_q <= 1'b0;
    end
  end

  assign flag_o = flag_q;

  // R7
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (set_i && !clr_all_i) |=> flag_o);

  // R6
  rd_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_i && !set_i) |=> !flag_o);

  // R6
  sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag_o && !rd_i && !clr_all_i) |=> flag_o);
endmodule

// File: rtl/dupid_detect.sv
module dupid_detect
  import dupid_pkg::*;
#(
  parameter int ID_W       = 8,
  parameter int CLK_PER_MS = 125000,
  parameter int SHORT_MS   = 210,
  parameter int LONG_MS    = 420,
  parameter int RESP_WIN   = 64
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            core_rst_i,
  input  logic [ID_W-1:0] node_id_i,
  input  logic            tok_seen_i,
  input  logic [ID_W-1:0] tok_did_i,
  input  logic            resp_seen_i,
  input  logic [1:0]      tmo_sel_i,
  input  logic            stat_rd_i,
  output logic            dup_flag_o,
  output logic            probe_done_o
);
  logic     active;
  tok_cls_e tok_cls;
  logic     hit;
  logic     win_open;
  logic     ms_tick;

  assign active = !core_rst_i && (node_id_i != '0);

  always_comb begin
    tok_cls = TOK_NONE;
    if (active && tok_seen_i) begin
      tok_cls = (tok_did_i == node_id_i) ? TOK_MATCH : TOK_OTHER;
    end
  end

  dupid_resp_window #(
    .RESP_WIN(RESP_WIN)
  ) u_win (
    .clk       (clk),
    .rst       (rst),
    .active_i  (active),
    .tok_cls_i (tok_cls),
    .resp_i    (resp_seen_i),
    .hit_o     (hit),
    .open_o    (win_open)
  );

  dupid_status_flag u_flag (
    .clk       (clk),
    .rst       (rst),
    .clr_all_i (core_rst_i),
    .set_i     (hit),
    .rd_i      (stat_rd_i),
    .flag_o    (dup_flag_o)
  );

  dupid_ms_tick #(
    .CLK_PER_MS(CLK_PER_MS)
  ) u_tick (
    .clk    (clk),
    .rst    (rst),
    .run_i  (active),
    .tick_o (ms_tick)
  );

  dupid_bound_timer #(
    .SHORT_MS(SHORT_MS),
    .LONG_MS (LONG_MS)
  ) u_bound (
    .clk     (clk),
    .rst     (rst),
    .run_i   (active),
    .tick_i  (ms_tick),
    .short_i (tmo_sel_i == TMO_SHORT_SEL),
    .done_o  (probe_done_o)
  );

  // R8
  idle_id_chk: assert property (@(posedge clk) disable iff (rst)
    (node_id_i == '0) |-> !hit);

  // R8
  core_rst_clr_chk: assert property (@(posedge clk) disable iff (rst)
    core_rst_i |=> (!dup_flag_o && !probe_done_o));

  // R2
  win_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (resp_seen_i && active && win_open && !core_rst_i) |=> dup_flag_o);
endmodule

// File: tb/dupid_detect_tb_top.sv
module dupid_detect_tb_top;
  localparam int ID_W  = 8;
  localparam int CPM   = 5;
  localparam int SHORT = 7;
  localparam int LONG  = 13;
  localparam int RW    = 6;

  logic            clk = 1'b0;
  logic            rst;
  logic            core_rst;
  logic [ID_W-1:0] node_id;
  logic            tok;
  logic [ID_W-1:0] did;
  logic            resp;
  logic [1:0]      tmo;
  logic            rd;
  logic            dup_flag;
  logic            probe_done;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  // bench model state
  logic m_flag = 1'b0;
  int   m_win = 0;
  int   m_act = 0;
  logic m_done = 1'b0;

  always #4 clk = ~clk;

  dupid_detect #(
    .ID_W(ID_W), .CLK_PER_MS(CPM), .SHORT_MS(SHORT), .LONG_MS(LONG), .RESP_WIN(RW)
  ) dut_i (
    .clk(clk), .rst(rst), .core_rst_i(core_rst), .node_id_i(node_id),
    .tok_seen_i(tok), .tok_did_i(did), .resp_seen_i(resp), .tmo_sel_i(tmo),
    .stat_rd_i(rd), .dup_flag_o(dup_flag), .probe_done_o(probe_done)
  );

  function automatic int bound_cycles(logic [1:0] sel);
    return ((sel == 2'b11) ? SHORT : LONG) * CPM + 1;
  endfunction

  task automatic check(string tag, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%0b exp=%0b t=%0t", tag, got, exp, $time);
    end
  endtask

  task automatic check_model(string tag);
    check({tag, " flag"}, dup_flag, m_flag);
    check({tag, " done"}, probe_done, m_done);
  endtask

  // advance one clock, updating the model from the inputs of this cycle
  task automatic cyc();
    logic act;
    logic hit;
    act = !rst && !core_rst && (node_id != '0);
    hit = act && (m_win > 0) && resp;
    if (rst || core_rst) m_flag = 1'b0;
    else if (hit) m_flag = 1'b1;
    else if (rd) m_flag = 1'b0;
    if (!act) m_win = 0;
    else if (tok && did == node_id) m_win = RW;
    else if (hit || tok) m_win = 0;
    else if (m_win > 0) m_win = m_win - 1;
    if (act) m_act = m_act + 1; else m_act = 0;
    m_done = act && (m_act >= bound_cycles(tmo));
    @(posedge clk);
    #1;
  endtask

  task automatic drive(logic t, logic [ID_W-1:0] d, logic r, logic h);
    tok = t; did = d; resp = r; rd = h;
    cyc();
    tok = 1'b0; resp = 1'b0; rd = 1'b0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, '0, 1'b0, 1'b0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int seed;
    seed = 32'h1d5e;
    void'($urandom(seed));
    rst = 1'b1; core_rst = 1'b0; node_id = 8'h5A; tok = 0; did = 0;
    resp = 0; tmo = 2'b11; rd = 0;
    #1;
    cyc(); cyc(); cyc();
    // R1 reset state
    check("R1 reset flag", dup_flag, 1'b0);
    check("R1 reset done", probe_done, 1'b0);
    rst = 1'b0;

    // R2 response mid-window
    drive(1, 8'h5A, 0, 0);
    idle(3);
    drive(0, 0, 1, 0);
    check("R2 mid-window", dup_flag, 1'b1);
    idle(2);
    check("R6 sticky", dup_flag, 1'b1);
    drive(0, 0, 0, 1);
    check("R6 read clears", dup_flag, 1'b0);

    // R2 last window cycle
    drive(1, 8'h5A, 0, 0);
    idle(RW - 1);
    drive(0, 0, 1, 0);
    check("R2 last window cycle", dup_flag, 1'b1);
    drive(0, 0, 0, 1);

    // R3 one cycle late
    drive(1, 8'h5A, 0, 0);
    idle(RW);
    drive(0, 0, 1, 0);
    check("R3 late response", dup_flag, 1'b0);
    drive(0, 0, 1, 0);
    check("R3 no token", dup_flag, 1'b0);

    // R5 same cycle as token
    drive(1, 8'h5A, 1, 0);
    check("R5 same cycle", dup_flag, 1'b0);
    idle(RW + 1);

    // R4 foreign token
    drive(1, 8'h33, 0, 0);
    drive(0, 0, 1, 0);
    check("R4 foreign token", dup_flag, 1'b0);
    drive(1, 8'h5A, 0, 0);
    idle(1);
    drive(1, 8'h21, 0, 0);
    drive(0, 0, 1, 0);
    check("R4 foreign closes window", dup_flag, 1'b0);

    // R10 single detection per window
    drive(1, 8'h5A, 0, 0);
    drive(0, 0, 1, 0);
    check("R10 first hit", dup_flag, 1'b1);
    drive(0, 0, 0, 1);
    drive(0, 0, 1, 0);
    check("R10 no second hit", dup_flag, 1'b0);
    idle(RW);

    // R7 read coincides with detection
    drive(1, 8'h5A, 0, 0);
    drive(0, 0, 1, 0);
    drive(1, 8'h5A, 0, 0);
    drive(0, 0, 1, 1);
    check("R7 set wins", dup_flag, 1'b1);
    drive(0, 0, 0, 1);
    check("R7 read after", dup_flag, 1'b0);

    // R8 zero node ID and core reset
    node_id = 8'h00;
    drive(1, 8'h00, 0, 0);
    drive(0, 0, 1, 0);
    check("R8 zero id flag", dup_flag, 1'b0);
    check("R8 zero id done", probe_done, 1'b0);
    node_id = 8'h5A;
    drive(1, 8'h5A, 0, 0);
    drive(0, 0, 1, 0);
    check("R8 re-armed", dup_flag, 1'b1);
    core_rst = 1'b1;
    drive(1, 8'h5A, 0, 0);
    check("R8 core reset clears", dup_flag, 1'b0);
    drive(0, 0, 1, 0);
    check("R8 core reset blocks", dup_flag, 1'b0);
    check("R8 core reset done", probe_done, 1'b0);

    // R9 short bound: edges while active counted from release
    tmo = 2'b11;
    core_rst = 1'b0;
    idle(SHORT * CPM);
    check("R9 short not yet", probe_done, 1'b0);
    idle(1);
    check("R9 short reached", probe_done, 1'b1);
    idle(4);
    check("R9 short holds", probe_done, 1'b1);
    core_rst = 1'b1;
    idle(1);
    check("R9 drops inactive", probe_done, 1'b0);
    tmo = 2'b01;
    core_rst = 1'b0;
    idle(SHORT * CPM + 1);
    check("R9 long not at short", probe_done, 1'b0);
    idle(LONG * CPM - SHORT * CPM - 1);
    check("R9 long not yet", probe_done, 1'b0);
    idle(1);
    check("R9 long reached", probe_done, 1'b1);
    check_model("R9 model");

    // random stream, R2 R3 R4 R6 R7 R10 against the bench model
    core_rst = 1'b1;
    tmo = 2'b10;
    idle(1);
    core_rst = 1'b0;
    for (int i = 0; i < 400; i++) begin
      logic t, r, h;
      logic [ID_W-1:0] d;
      t = ($urandom % 4) == 0;
      d = (($urandom % 2) == 0) ? 8'h5A : 8'($urandom);
      r = ($urandom % 4) == 0;
      h = ($urandom % 8) == 0;
      drive(t, d, r, h);
      check_model("R2 R3 R4 R6 R7 R10 random");
    end
    finish_run();
  end
endmodule